// File: doc/BRIEF.md
# Processor Bus Cycle Timing Sequencer

This block times every bus cycle a processor core issues, counted in master-clock ticks. The core hands it one request at a time: an internal cycle that touches no memory, a memory read, or a memory write, along with a 24-bit address and a write byte. Internal cycles always take six ticks. Memory cycles take six, eight or twelve ticks, depending on where the address falls in the memory map and on a fast-ROM enable bit that software sets by writing a control register.

Inside a cycle the block marks the first tick and the final tick with strobes. On a read it samples the bus data four ticks before the end, then lets the cycle run out. On a write it drives the data at the final tick. The byte last moved in either direction stays in a memory data register. The done strobe tells the core the cycle is over. The sequencer then spends one idle clock before it takes the next request.

Top module: `bus_cycle_seq`

## Requirements
- R1: A request with `req_kind` 2'b00 (internal) or 2'b11 (treated as internal) lasts exactly 6 ticks at any address and with either fast-ROM setting.
- R2: In banks 0x00-0x3F, and in banks 0x80-0xBF below offset 0x8000, a read (2'b01) or write (2'b10) lasts 8 ticks at offsets 0x0000-0x1FFF, 6 at 0x2000-0x3FFF, 12 at 0x4000-0x41FF, 6 at 0x4200-0x5FFF and 8 at 0x6000 and above.
- R3: Memory cycles in banks 0x40-0x7F last 8 ticks. Memory cycles in banks 0xC0-0xFF, or in banks 0x80-0xBF at offsets 0x8000 and above, last 6 ticks when fast-ROM is set and 8 when it is clear.
- R4: On a read, `rd_strobe` is high for the single tick numbered (length - 4), counting the first tick as 1. `bus_rdata` is captured into `mdr` at the end of that tick. Later changes on `bus_rdata` do not alter `mdr`.
- R5: On a write, `wr_strobe` is high only on the final tick, with `bus_wdata` equal to the requested byte. `mdr` holds that byte after the cycle.
- R6: `cycle_start` is high only on tick 1 and `cycle_done` only on the final tick, for every kind of cycle. `bus_addr` shows the request address while a strobe is high.
- R7: A request is taken only while the block is idle. A request already present during the done tick starts its first tick two clocks after the done tick. A request raised while idle starts its first tick on the next clock.
- R8: A completed write to offset 0x420D in banks 0x00-0x3F or 0x80-0xBF copies data bit 0 into the fast-ROM bit. The new value first governs the next cycle.
- R9: After reset the block is idle, all strobes are low, `mdr` is 0x00 and fast-ROM is clear.
- R10: An internal cycle raises neither data strobe and leaves `mdr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one tick per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 internal, 01 read, 10 write, 11 internal |
| req_addr | input | 24 | Bank in bits 23:16, offset in bits 15:0 |
| req_wdata | input | 8 | Byte to write |
| bus_rdata | input | 8 | Data returned by memory |
| cycle_start | output | 1 | First tick of a cycle |
| cycle_done | output | 1 | Final tick of a cycle |
| rd_strobe | output | 1 | Read sample tick |
| wr_strobe | output | 1 | Write drive tick |
| bus_addr | output | 24 | Address of the cycle in progress |
| bus_wdata | output | 8 | Byte driven on a write |
| mdr | output | 8 | Last byte transferred |
| busy | output | 1 | A cycle is in progress |

## Verification
The write strobe, the done strobe and the fast-ROM register update all fall on the final tick of a write to the control register. In the same instant the sequencer goes idle and the length of the next access must come from the new bit. The bench provokes this with directed writes of both bit values to 0x420D, and with random writes to that offset in both mirror banks. Each is followed at once by an access in the fast-ROM region. The check is that the following cycle, and not the write itself, has the 6- or 8-tick length the updated bit calls for.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef logic [1:0] kind_t;
  localparam kind_t K_IO = 2'b00;
  localparam kind_t K_RD = 2'b01;
  localparam kind_t K_WR = 2'b10;

  localparam int TICK_W = 4;
  localparam logic [TICK_W-1:0] T_FAST = 4'd6;
  localparam logic [TICK_W-1:0] T_SLOW = 4'd8;
  localparam logic [TICK_W-1:0] T_XSLOW = 4'd12;
  localparam logic [15:0] CTRL_OFS = 16'h420D;

  // Memory cycle length for a 24-bit address
  function automatic logic [TICK_W-1:0] mem_ticks(input logic [23:0] a, input logic fast);
    logic [7:0] bank;
    logic [15:0] ofs;
    logic [TICK_W-1:0] t;
    bank = a[23:16];
    ofs = a[15:0];
    if (bank[7] && (bank[6] || ofs[15]))
      t = fast ? T_FAST : T_SLOW;
    else if (bank[6])
      t = T_SLOW;
    else if (ofs < 16'h2000)
      t = T_SLOW;
    else if (ofs < 16'h4000)
      t = T_FAST;
    else if (ofs < 16'h4200)
      t = T_XSLOW;
    else if (ofs < 16'h6000)
      t = T_FAST;
    else
      t = T_SLOW;
    return t;
  endfunction

  // Control register decode: system banks only
  function automatic logic ctrl_hit(input logic [23:0] a);
    return !a[22] && (a[15:0] == CTRL_OFS);
  endfunction
endpackage

// File: rtl/bcs_speed.sv
module bcs_speed
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W = TICK_W,
  parameter logic [CNT_W-1:0] IO_TICKS = CNT_W'(6)
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              fast,
  output logic [CNT_W-1:0]  ticks
);
  logic is_mem;
  assign is_mem = (kind == K_RD) || (kind == K_WR);
  assign ticks = is_mem ? CNT_W'(mem_ticks(addr, fast)) : IO_TICKS;
endmodule

// File: rtl/bcs_sequencer.sv
module bcs_sequencer
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int CNT_W = TICK_W,
  parameter int LEAD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  len_in,
  output logic              active,
  output logic              ev_start,
  output logic              ev_done,
  output logic              ev_rd,
  output logic              ev_wr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] LEAD_C = CNT_W'(LEAD);

  logic [CNT_W-1:0] cnt, len_q;
  kind_t kind_q;
  logic accept;

  assign accept = !active && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      len_q   <= '0;
      kind_q  <= K_IO;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      active  <= 1'b1;
      cnt     <= ONE;
      len_q   <= len_in;
      kind_q  <= req_kind;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end else if (active) begin
      if (cnt == len_q) active <= 1'b0;
      else cnt <= cnt + ONE;
    end
  end

  assign ev_start = active && (cnt == ONE);
  assign ev_done  = active && (cnt == len_q);
  assign ev_rd    = active && (kind_q == K_RD) && (cnt == len_q - LEAD_C);
  assign ev_wr    = ev_done && (kind_q == K_WR);

  // R6: first and final tick never coincide
  a_r6_start_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> !ev_done);
  // R7: one idle clock follows every done tick
  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !active);
  // R4: sample tick precedes the end by more than one tick
  a_r4_rd_early: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd |=> (active && !ev_done));
  // R5: write strobe closes the cycle
  a_r5_wr_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> !active);
  // R2: only legal lengths are ever run
  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> (len_q == CNT_W'(6) || len_q == CNT_W'(8) || len_q == CNT_W'(12)));
  // R8: length is frozen once a cycle runs
  a_r8_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ev_start) |-> $stable(len_q));
endmodule

// File: rtl/bcs_datareg.sv
module bcs_datareg
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rd,
  input  logic              ev_wr,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] mdr,
  output logic              fast
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdr  <= '0;
      fast <= 1'b0;
    end else begin
      if (ev_rd) mdr <= bus_rdata;
      else if (ev_wr) mdr <= wdata_q;
      if (ev_wr && ctrl_hit(24'(addr_q))) fast <= wdata_q[0];
    end
  end

  // R8: fast-ROM bit moves only after a write strobe
  a_r8_fast_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fast) |-> $past(ev_wr));
  // R10: data register holds without a strobe
  a_r10_mdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_rd && !ev_wr) |=> $stable(mdr));
  // R4/R5: the two strobes are exclusive
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rd && ev_wr));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int CNT_W = TICK_W,
  parameter int LEAD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              cycle_start,
  output logic              cycle_done,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] mdr,
  output logic              busy
);
  logic [CNT_W-1:0] len_w;
  logic fast_w;

  bcs_speed #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_speed (
    .kind(req_kind), .addr(req_addr), .fast(fast_w), .ticks(len_w)
  );

  bcs_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .LEAD(LEAD)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .len_in(len_w),
    .active(busy), .ev_start(cycle_start), .ev_done(cycle_done),
    .ev_rd(rd_strobe), .ev_wr(wr_strobe), .addr_q(bus_addr), .wdata_q(bus_wdata)
  );

  bcs_datareg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .ev_rd(rd_strobe), .ev_wr(wr_strobe),
    .bus_rdata(bus_rdata), .wdata_q(bus_wdata), .addr_q(bus_addr),
    .mdr(mdr), .fast(fast_w)
  );

  // R6: start only appears out of an idle clock
  a_r6_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> $past(!busy));
endmodule

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [23:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] bus_rdata = '0;
  logic cycle_start, cycle_done, rd_strobe, wr_strobe, busy;
  logic [23:0] bus_addr;
  logic [7:0] bus_wdata, mdr;

  int n_chk = 0;
  int n_bad = 0;
  bit fast_m = 1'b0;
  logic [7:0] mdr_m = 8'h00;
  bit piped = 1'b0;

  always #2.5 clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .bus_rdata(bus_rdata),
    .cycle_start(cycle_start), .cycle_done(cycle_done), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .mdr(mdr), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_len(input logic [1:0] k, input logic [23:0] a, input bit f);
    int b, o;
    b = int'(a[23:16]);
    o = int'(a[15:0]);
    if (k != 2'b01 && k != 2'b10) return 6;
    if (b >= 'hC0 || (b >= 'h80 && o >= 'h8000)) return f ? 6 : 8;
    if (b >= 'h40 && b < 'h80) return 8;
    if (o < 'h2000) return 8;
    if (o < 'h4000) return 6;
    if (o < 'h4200) return 12;
    if (o < 'h6000) return 6;
    return 8;
  endfunction

  function automatic string len_req(input logic [1:0] k, input logic [23:0] a);
    if (k != 2'b01 && k != 2'b10) return "R1";
    if (a[23:16] >= 8'hC0 || a[23:22] == 2'b01 || (a[23] && a[15])) return "R3";
    return "R2";
  endfunction

  // One full cycle; leaves the bench at the negedge of the done tick when nxt_piped is set
  task automatic run(input logic [1:0] k, input logic [23:0] a, input logic [7:0] wd,
                     input logic [7:0] rd, input bit nxt_piped);
    int gap, tick, rd_t, wr_t, el;
    bit flip;
    el = ref_len(k, a, fast_m);
    bus_rdata = rd;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    gap = 0;
    do begin @(negedge clk); gap++; end while (!cycle_start && gap < 20);
    req_valid = 1'b0; req_addr = 24'($urandom); req_wdata = 8'($urandom);
    check(gap == (piped ? 2 : 1), "R7", gap, piped ? 2 : 1);
    tick = 1; rd_t = 0; wr_t = 0; flip = 1'b0;
    while (1) begin
      if (flip) begin bus_rdata = ~rd; flip = 1'b0; end
      if (tick > 1 && cycle_start) check(0, "R6", tick, 1);
      if (rd_strobe) begin
        rd_t = tick; flip = 1'b1;
        check(bus_addr == a, "R6", int'(bus_addr), int'(a));
      end
      if (wr_strobe) begin
        wr_t = tick;
        check(bus_wdata == wd, "R5", int'(bus_wdata), int'(wd));
        check(bus_addr == a, "R6", int'(bus_addr), int'(a));
      end
      if (cycle_done || tick > 20) break;
      @(negedge clk); tick++;
    end
    check(tick == el, len_req(k, a), tick, el);
    if (k == 2'b01) begin
      check(rd_t == el - 4, "R4", rd_t, el - 4);
      mdr_m = rd;
    end else check(rd_t == 0, "R10", rd_t, 0);
    if (k == 2'b10) begin
      check(wr_t == el, "R5", wr_t, el);
      mdr_m = wd;
      if (!a[22] && a[15:0] == 16'h420D) fast_m = wd[0];
    end else check(wr_t == 0, "R10", wr_t, 0);
    piped = nxt_piped;
    if (nxt_piped) return;
    @(negedge clk);
    check(!busy, "R7", busy, 0);
    check(mdr == mdr_m, k == 2'b01 ? "R4" : (k == 2'b10 ? "R5" : "R10"), mdr, mdr_m);
  endtask

  function automatic logic [23:0] pick_addr();
    logic [7:0] b;
    logic [15:0] o;
    b = 8'($urandom);
    case ($urandom % 12)
      0: o = 16'h1FFF;  1: o = 16'h2000;  2: o = 16'h3FFF;  3: o = 16'h4000;
      4: o = 16'h41FF;  5: o = 16'h4200;  6: o = 16'h5FFF;  7: o = 16'h6000;
      8: o = 16'h7FFF;  9: o = 16'h8000;  10: o = 16'h420D;
      default: o = 16'($urandom);
    endcase
    if (o == 16'h420D) b = ($urandom % 2) ? 8'h00 : 8'h80;
    return {b, o};
  endfunction

  task automatic main();
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !cycle_start && !cycle_done, "R9", busy, 0);
    check(!rd_strobe && !wr_strobe, "R9", rd_strobe, 0);
    check(mdr == 8'h00, "R9", mdr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: fast-ROM clear after reset gives 8 ticks
    run(2'b01, 24'hC01234, 8'h00, 8'h5A, 1'b0);
    // R1: internal ignores address and kind 11
    run(2'b00, 24'h004000, 8'h11, 8'hEE, 1'b0);
    run(2'b11, 24'hC08000, 8'h22, 8'hEE, 1'b0);
    // R2: region boundaries
    run(2'b01, 24'h001FFF, 8'h00, 8'h01, 1'b0);
    run(2'b10, 24'h002000, 8'h33, 8'h00, 1'b0);
    run(2'b01, 24'h3F41FF, 8'h00, 8'h02, 1'b0);
    run(2'b10, 24'h804200, 8'h44, 8'h00, 1'b0);
    run(2'b01, 24'h806000, 8'h00, 8'h03, 1'b0);
    run(2'b01, 24'h7E0000, 8'h00, 8'h04, 1'b0);
    // R8: enable fast-ROM and use it at once (piped)
    run(2'b10, 24'h00420D, 8'h01, 8'h00, 1'b1);
    run(2'b01, 24'h808000, 8'h00, 8'hA5, 1'b1);
    run(2'b01, 24'hFFFFFF, 8'h00, 8'h3C, 1'b0);
    run(2'b01, 24'h408000, 8'h00, 8'h3D, 1'b0);
    // R8: mirror-bank write clears it; a bank 0x40 write does not decode
    run(2'b10, 24'h80420D, 8'hFE, 8'h00, 1'b1);
    run(2'b01, 24'hC00000, 8'h00, 8'h77, 1'b0);
    run(2'b10, 24'h40420D, 8'h01, 8'h00, 1'b1);
    run(2'b01, 24'hC00000, 8'h00, 8'h78, 1'b0);
    // random mix
    for (int i = 0; i < 120; i++) begin
      logic [1:0] k;
      k = 2'($urandom);
      run(k, pick_addr(), 8'($urandom), 8'($urandom), bit'($urandom % 2));
    end
    if (piped) @(negedge clk);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    void'($urandom(32'd2024));
    fork
      main();
      begin repeat (100000) @(posedge clk); timed_out = 1'b1; end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule